// File: doc/BRIEF.md
# Prescaled Counter Timer with Hexadecimal Display

This block is a slow event counter that lives in a fast system clock domain, nominally 50 MHz. A toggle-based prescaler divides the system clock by twice a programmable scale value. The count restarts and the divided phase flips each time the count completes a span of `SCALE` cycles, so one full slow period lasts `2*SCALE` system cycles. A scale of 25,000,000 gives a 1 Hz period from a 50 MHz clock.

The prescaler does not drive any flip-flop as a clock. Once per slow period it produces a single-cycle step enable. On that cycle an 8-bit binary count advances by one, provided the active-high enable input is high.

The count is shown as two hexadecimal digits on two active-low seven-segment buses. The upper nibble drives the left digit and the lower nibble drives the right digit. A synchronous active-low reset clears the count, the prescaler count and the prescaler phase.

Top module: `prescaled_hex_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count is cleared, so both displays show the glyph for 0 (7'h40).
- R2: After `rst_n` is released, the first step is taken on the `2*SCALE`-th rising edge. The display still shows 00 after `2*SCALE-1` edges.
- R3: While `enable` is high, the count rises by exactly one every `2*SCALE` system cycles and holds in between.
- R4: If `enable` is low on the edge where a step is due, that step is skipped and the count holds. The prescaler keeps its rhythm, so later steps stay on the `2*SCALE` grid.
- R5: The count wraps from 0xFF to 0x00 on the next enabled step.
- R6: `seg_hi` shows count bits [7:4] and `seg_lo` shows bits [3:0]. Both are active low, with bit 6 = segment g down to bit 0 = segment a. The glyphs for 0 to F are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10, 08, 03, 46, 21, 06, 0E (hex), so b and d are lowercase.
- R7: A reset applied mid-run also clears the prescaler phase, so the first step after release again comes after exactly `2*SCALE` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows the count to step on a slow tick, active high |
| seg_hi | output | 7 | Upper-nibble digit, active low, bits g..a |
| seg_lo | output | 7 | Lower-nibble digit, active low, bits g..a |

## Verification
The segment outputs are decoded combinationally from the count register. A step is therefore visible right after the edge that takes it: edge `2*SCALE`, `4*SCALE` and so on, counted from reset release.

The bench drives inputs and samples outputs on falling edges, and counts falling edges from the release of reset. With `SCALE = 3`, it samples at the end of each six-cycle block, and at cycle 5 and cycle 6 when it checks that a step is neither early nor late. Expected glyphs come from the bench's own table, and every one of the 256 count values is compared on the way through the wrap.

// File: rtl/tmr_pkg.sv
// Package: shared constants for the prescaled timer.
// Assumes the display digits are four bits wide and have seven segments.
package tmr_pkg;
    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    typedef logic [NIB_W-1:0] nibble_t;
    typedef logic [SEG_W-1:0] glyph_t;
endpackage

// File: rtl/tick_divider.sv
// Module: tick_divider
// Toggle prescaler. The phase flips every SCALE cycles, so one slow
// period lasts 2*SCALE cycles. A single-cycle tick is raised on the
// cycle that ends the high half of the period.
// Assumes SCALE >= 1 and that SCALE-1 fits in CNT_W bits.
module tick_divider #(
    parameter int SCALE = 25_000_000,
    parameter int CNT_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SCALE - 1);

    logic [CNT_W-1:0] span_q;
    logic             phase_q;
    logic             span_end;

    assign span_end = (span_q == LAST);
    assign tick     = span_end && phase_q;

    // Purpose: count through one half period, then restart and flip phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q  <= '0;
            phase_q <= 1'b0;
        end else if (span_end) begin
            span_q  <= '0;
            phase_q <= ~phase_q;
        end else begin
            span_q  <= span_q + 1'b1;
        end
    end

    // R3: the prescaler count never runs past its last value.
    a_r3_span_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        span_q <= LAST);

    // R3: a tick never lasts two cycles in a row.
    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/step_counter.sv
// Module: step_counter
// Binary counter that adds one on each tick while advance is high.
// It wraps silently at the top of its range.
// Assumes tick is a single-cycle pulse in the same clock domain.
module step_counter #(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             advance,
    output logic [VAL_W-1:0] value
);
    // Purpose: hold the count, and step it by one on an enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (tick && advance) begin
            value <= value + 1'b1;
        end
    end

    // R1: the first cycle out of reset starts from zero.
    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (value == '0));

    // R3 / R5: an enabled tick moves the count by exactly one, modulo the width.
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && advance) |=> (value == $past(value) + 1'b1));

    // R4: with no enabled tick, the count holds.
    a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && advance) |=> $stable(value));
endmodule

// File: rtl/hex_glyph.sv
// Module: hex_glyph
// Maps one hexadecimal digit to an active-low seven-segment pattern,
// bit 6 = g down to bit 0 = a, with lowercase b and d.
// Purely combinational; assumes the consumer tolerates decode glitches.
module hex_glyph
    import tmr_pkg::*;
(
    input  nibble_t digit,
    output glyph_t  segs
);
    // Purpose: look up the lit-segment pattern for the digit.
    always_comb begin
        unique case (digit)
            4'h0:    segs = 7'h40;
            4'h1:    segs = 7'h79;
            4'h2:    segs = 7'h24;
            4'h3:    segs = 7'h30;
            4'h4:    segs = 7'h19;
            4'h5:    segs = 7'h12;
            4'h6:    segs = 7'h02;
            4'h7:    segs = 7'h78;
            4'h8:    segs = 7'h00;
            4'h9:    segs = 7'h10;
            4'hA:    segs = 7'h08;
            4'hB:    segs = 7'h03;
            4'hC:    segs = 7'h46;
            4'hD:    segs = 7'h21;
            4'hE:    segs = 7'h06;
            default: segs = 7'h0E;
        endcase
    end
endmodule

// File: rtl/prescaled_hex_timer.sv
// Module: prescaled_hex_timer
// Top level: prescaler tick, then the enabled 8-bit count, then one
// glyph decoder per nibble.
// Assumes VAL_W = 8, so there are exactly two digits (high and low).
module prescaled_hex_timer
    import tmr_pkg::*;
#(
    parameter int SCALE = 25_000_000,
    parameter int CNT_W = 32,
    parameter int VAL_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    output logic [6:0] seg_hi,
    output logic [6:0] seg_lo
);
    localparam int NDIG = VAL_W / NIB_W;

    logic             tick;
    logic [VAL_W-1:0] value;
    glyph_t           glyphs [NDIG];

    tick_divider #(.SCALE(SCALE), .CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    step_counter #(.VAL_W(VAL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .advance (enable),
        .value   (value)
    );

    for (genvar d = 0; d < NDIG; d++) begin : g_digit
        hex_glyph u_glyph (
            .digit (value[d*NIB_W +: NIB_W]),
            .segs  (glyphs[d])
        );
    end

    assign seg_lo = glyphs[0];
    assign seg_hi = glyphs[NDIG-1];
endmodule

// File: tb/prescaled_hex_timer_bench.sv
`timescale 1ns/1ps
module prescaled_hex_timer_bench;
    localparam int SC  = 3;
    localparam int PER = 2 * SC;
    localparam int NV  = 8;
    // Each entry: {enable for the block, expected count at the end of the block}.
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 8'h01}, {1'b1, 8'h02}, {1'b0, 8'h02}, {1'b1, 8'h03},
        {1'b0, 8'h03}, {1'b0, 8'h03}, {1'b1, 8'h04}, {1'b1, 8'h05}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [6:0] seg_hi, seg_lo;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prescaled_hex_timer #(.SCALE(SC)) u_prescaled_hex_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .seg_hi(seg_hi), .seg_lo(seg_lo)
    );

    function automatic logic [6:0] ref_glyph(input logic [3:0] n);
        logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                               7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
        return t[n];
    endfunction

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (seg_hi !== ref_glyph(exp[7:4]) || seg_lo !== ref_glyph(exp[3:0])) begin
            errors++;
            $display("FAIL %s: got hi=%h lo=%h, expected hi=%h lo=%h (count %h)",
                     req, seg_hi, seg_lo, ref_glyph(exp[7:4]), ref_glyph(exp[3:0]), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        enable = 1'b1;
        wait_n(3);
        check("R1", 8'h00);
        rst_n = 1'b1;

        // Table walk: R3 step per period, R4 skipped step on enable low
        for (int i = 0; i < NV; i++) begin
            enable = VEC[i][8];
            wait_n(PER);
            check(VEC[i][8] ? "R3" : "R4", VEC[i][7:0]);
        end

        // R4: enable pulsed high between ticks only, so no step
        enable = 1'b1;
        wait_n(PER - 1);
        enable = 1'b0;
        wait_n(1);
        check("R4", 8'h05);

        // R7 / R2: mid-run reset clears the prescaler phase
        enable = 1'b1;
        wait_n(2);
        do_reset();
        check("R1", 8'h00);
        wait_n(PER - 1);
        check("R2", 8'h00);
        wait_n(1);
        check("R7", 8'h01);

        // R6 / R5: every glyph pair through a full wrap
        do_reset();
        for (int v = 1; v <= 256; v++) begin
            wait_n(PER);
            check(v == 256 ? "R5" : "R6", 8'(v));
        end
        wait_n(PER);
        check("R5", 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule